// File: doc/BRIEF.md
# Adaptive Morse Code Decoder

This block turns a keyed on/off Morse input into a stream of ASCII bytes for a downstream UART transmit FIFO. It measures how long the key stays down and how long it stays up, in clock cycles, and judges each duration against a running estimate of the unit length (the length of one dot). The estimate follows the sender, so a slow or fast operator is decoded without retuning.

Tones become dots or dashes and are folded into a binary tree index. Gaps either separate elements, end a character, or end a word. A character is emitted while the key is still up, as soon as the gap is long enough, and the tree index is then mapped to an ASCII code. A word gap adds an ASCII space. Bytes are written only when the FIFO is not full. A byte that meets a full FIFO is dropped, and a sticky flag records the loss.

The key input is expected to be synchronised to `clk` already. The parameters must satisfy 2 <= UNIT_MIN <= UNIT_INIT <= UNIT_MAX, and six times UNIT_MAX must fit in CNT_W bits.

Top module: `morse_decoder`

## Requirements
- R1: While reset is held and right after it, `fifo_wr` is low and `overflow` is low. The unit estimate starts at UNIT_INIT.
- R2: A tone of length L, with unit estimate u, is a dot when u/2 <= L < 2u and a dash when 2u <= L < 6u. Any other tone (a glitch or an overlong tone) adds no element.
- R3: After each dot the unit estimate becomes (u + L)/2, rounded down and then clamped to [UNIT_MIN, UNIT_MAX]. Dashes and gaps leave it unchanged.
- R4: A key-up gap shorter than 2u only separates elements. When a gap reaches 2u and elements are pending, the character is written out during that gap.
- R5: The tree index starts at 1. A dot maps n to 2n and a dash maps n to 2n+1. Letters A–Z, digits 0–9, '.', ',' and '?' decode to their ASCII codes. Any other index yields '?' (0x3F).
- R6: A character with more than 6 elements is written as '?' (0x3F).
- R7: When a gap reaches 5u after a character was emitted in that gap, exactly one ASCII space (0x20) follows that character. An idle line with no pending character writes nothing.
- R8: `fifo_wr` is asserted only while `fifo_full` is low. A byte that is due while `fifo_full` is high is dropped and sets `overflow`, which stays set until reset.
- R9: Each emitted byte produces a `fifo_wr` pulse of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| key_in | input | 1 | Keyed line, high while the tone is on |
| fifo_full | input | 1 | Downstream FIFO cannot accept a byte |
| fifo_wr | output | 1 | Write strobe to the FIFO |
| fifo_data | output | 8 | ASCII byte, valid while `fifo_wr` is high |
| overflow | output | 1 | Sticky flag: a byte was dropped because the FIFO was full |

## Verification
The bench builds the decoder with CNT_W=10, UNIT_INIT=8, UNIT_MIN=4 and UNIT_MAX=32. With these values a whole character or word gap lasts only tens of cycles. Changing the sending unit between 4 and 12 cycles makes the estimate move visibly from character to character. Ramping down to 4-cycle units brings the lower clamp within reach. At that point a 2-cycle dot would pull an unclamped estimate low enough to turn a 7-cycle tone into a dash, so the clamp shows up in the decoded letter.

// File: rtl/morse_pkg.sv
// Shared definitions for the Morse decoder.
// Assumes nothing beyond IEEE 1800-2017 packages.
package morse_pkg;

    // Kind of element produced by the classifier for one tone.
    typedef enum logic [1:0] {
        ELEM_NONE = 2'd0,
        ELEM_DOT  = 2'd1,
        ELEM_DASH = 2'd2
    } elem_t;

    localparam logic [7:0] ASCII_SPACE   = 8'h20;
    localparam logic [7:0] ASCII_UNKNOWN = 8'h3F;

endpackage

// File: rtl/morse_edge_timer.sv
// Edge detector and run-length counter for the keyed line.
// Counts the cycles spent in the present key level, reports the length of
// each finished tone, and exposes the live length of the present run.
// Assumes key_in is already synchronous to clk.
module morse_edge_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_in,
    output logic             key_lvl,
    output logic [CNT_W-1:0] run_len,
    output logic             tone_done,
    output logic [CNT_W-1:0] tone_len
);

    logic key_edge;

    // Purpose: flag a change of level between the input and its registered copy.
    always_comb begin
        key_edge = (key_in != key_lvl);
    end

    // Purpose: register the level, restart the run counter on an edge, latch tone length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_lvl   <= 1'b0;
            run_len   <= '0;
            tone_done <= 1'b0;
            tone_len  <= '0;
        end else begin
            key_lvl   <= key_in;
            tone_done <= 1'b0;
            if (key_edge) begin
                run_len <= CNT_W'(1);
                if (key_lvl) begin
                    tone_done <= 1'b1;
                    tone_len  <= run_len;
                end
            end else if (run_len != '1) begin
                run_len <= run_len + 1'b1;
            end
        end
    end

    AST_TONE_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tone_done |-> (tone_len != '0)); // R2

endmodule

// File: rtl/morse_classifier.sv
// Adaptive classifier: holds the unit estimate, labels each tone as dot,
// dash or reject, and raises one-cycle events when a gap reaches the
// character or word threshold.
// Assumes UNIT_MIN >= 2 and 6*UNIT_MAX fits in CNT_W bits.
module morse_classifier
    import morse_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int UNIT_INIT = 60,
    parameter int UNIT_MIN  = 8,
    parameter int UNIT_MAX  = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tone_done,
    input  logic [CNT_W-1:0] tone_len,
    input  logic             key_lvl,
    input  logic [CNT_W-1:0] run_len,
    output elem_t            elem,
    output logic             char_end,
    output logic             word_end,
    output logic [CNT_W-1:0] unit
);

    localparam int               TH_W    = CNT_W + 3;
    localparam logic [TH_W-1:0]  MIN_W   = TH_W'(UNIT_MIN);
    localparam logic [TH_W-1:0]  MAX_W   = TH_W'(UNIT_MAX);
    localparam logic [CNT_W-1:0] MIN_C   = CNT_W'(UNIT_MIN);
    localparam logic [CNT_W-1:0] MAX_C   = CNT_W'(UNIT_MAX);
    localparam logic [CNT_W-1:0] INIT_C  = CNT_W'(UNIT_INIT);

    logic [TH_W-1:0]  u_w, len_w, gap_w;
    logic [TH_W-1:0]  th_half, th_dash, th_long, th_word, avg_w;
    logic [CNT_W-1:0] unit_next;
    logic             is_dot, is_dash;

    // Purpose: derive all thresholds from the live unit estimate by shifts and adds.
    always_comb begin
        u_w     = TH_W'(unit);
        len_w   = TH_W'(tone_len);
        gap_w   = TH_W'(run_len);
        th_half = u_w >> 1;
        th_dash = u_w << 1;
        th_long = (u_w << 2) + (u_w << 1);
        th_word = (u_w << 2) + u_w;
    end

    // Purpose: average a fresh dot into the estimate and clamp it to the allowed range.
    always_comb begin
        avg_w = (u_w + len_w) >> 1;
        if (avg_w < MIN_W) begin
            unit_next = MIN_C;
        end else if (avg_w > MAX_W) begin
            unit_next = MAX_C;
        end else begin
            unit_next = avg_w[CNT_W-1:0];
        end
    end

    // Purpose: label a finished tone against the dot and dash windows.
    always_comb begin
        is_dot  = tone_done && (len_w >= th_half) && (len_w < th_dash);
        is_dash = tone_done && (len_w >= th_dash) && (len_w < th_long);
    end

    // Purpose: register element labels, unit updates and gap threshold events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elem     <= ELEM_NONE;
            char_end <= 1'b0;
            word_end <= 1'b0;
            unit     <= INIT_C;
        end else begin
            elem     <= ELEM_NONE;
            char_end <= 1'b0;
            word_end <= 1'b0;
            if (is_dot) begin
                elem <= ELEM_DOT;
                unit <= unit_next;
            end else if (is_dash) begin
                elem <= ELEM_DASH;
            end
            if (!key_lvl) begin
                char_end <= (gap_w == th_dash);
                word_end <= (gap_w == th_word);
            end
        end
    end

    AST_UNIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (unit >= MIN_C) && (unit <= MAX_C)); // R3
    AST_ELEM_AFTER_TONE: assert property (@(posedge clk) disable iff (!rst_n)
        (elem != ELEM_NONE) |-> $past(tone_done)); // R2
    AST_GAP_EVENTS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(char_end && word_end)); // R4

endmodule

// File: rtl/morse_tree_lut.sv
// Maps a finished tree index (root 1, dot 2n, dash 2n+1) to ASCII.
// Unlisted indices return '?'. Purely combinational.
module morse_tree_lut
    import morse_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       ascii
);

    int unsigned iv;

    // Purpose: decode the tree index; letters, digits and three punctuation marks.
    always_comb begin
        iv = 32'(idx);
        case (iv)
            2:  ascii = 8'h45; // E
            3:  ascii = 8'h54; // T
            4:  ascii = 8'h49; // I
            5:  ascii = 8'h41; // A
            6:  ascii = 8'h4E; // N
            7:  ascii = 8'h4D; // M
            8:  ascii = 8'h53; // S
            9:  ascii = 8'h55; // U
            10: ascii = 8'h52; // R
            11: ascii = 8'h57; // W
            12: ascii = 8'h44; // D
            13: ascii = 8'h4B; // K
            14: ascii = 8'h47; // G
            15: ascii = 8'h4F; // O
            16: ascii = 8'h48; // H
            17: ascii = 8'h56; // V
            18: ascii = 8'h46; // F
            20: ascii = 8'h4C; // L
            22: ascii = 8'h50; // P
            23: ascii = 8'h4A; // J
            24: ascii = 8'h42; // B
            25: ascii = 8'h58; // X
            26: ascii = 8'h43; // C
            27: ascii = 8'h59; // Y
            28: ascii = 8'h5A; // Z
            29: ascii = 8'h51; // Q
            32: ascii = 8'h35; // 5
            33: ascii = 8'h34; // 4
            35: ascii = 8'h33; // 3
            39: ascii = 8'h32; // 2
            47: ascii = 8'h31; // 1
            48: ascii = 8'h36; // 6
            56: ascii = 8'h37; // 7
            60: ascii = 8'h38; // 8
            62: ascii = 8'h39; // 9
            63: ascii = 8'h30; // 0
            76: ascii = 8'h3F; // ?
            85: ascii = 8'h2E; // .
            115: ascii = 8'h2C; // ,
            default: ascii = ASCII_UNKNOWN;
        endcase
    end

endmodule

// File: rtl/morse_assembler.sv
// Builds the tree index from elements, emits a character or a space on
// gap events, and writes to the FIFO only when it is not full.
// Assumes an element and a gap event never arrive in the same cycle
// (guaranteed by UNIT_MIN >= 2 in the classifier).
module morse_assembler
    import morse_pkg::*;
#(
    parameter int MAX_ELEMS = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  elem_t      elem,
    input  logic       char_end,
    input  logic       word_end,
    input  logic       fifo_full,
    output logic       fifo_wr,
    output logic [7:0] fifo_data,
    output logic       overflow
);

    localparam int IDX_W  = MAX_ELEMS + 1;
    localparam int CNT_EW = $clog2(MAX_ELEMS + 1);

    logic [IDX_W-1:0]  idx;
    logic [CNT_EW-1:0] n_elem;
    logic              too_long, word_pend;
    logic [7:0]        lut_ascii;
    logic              emit_char, emit_space, emit;

    morse_tree_lut #(.IDX_W(IDX_W)) u_lut (
        .idx   (idx),
        .ascii (lut_ascii)
    );

    // Purpose: decide what is due this cycle and gate the write on FIFO space.
    always_comb begin
        emit_char  = char_end && (n_elem != '0);
        emit_space = word_end && word_pend;
        emit       = emit_char || emit_space;
        if (emit_space) begin
            fifo_data = ASCII_SPACE;
        end else if (too_long) begin
            fifo_data = ASCII_UNKNOWN;
        end else begin
            fifo_data = lut_ascii;
        end
        fifo_wr = emit && !fifo_full;
    end

    // Purpose: walk the tree on each element and restart it after a character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= IDX_W'(1);
            n_elem   <= '0;
            too_long <= 1'b0;
        end else if (emit_char) begin
            idx      <= IDX_W'(1);
            n_elem   <= '0;
            too_long <= 1'b0;
        end else if (elem != ELEM_NONE) begin
            if (n_elem == CNT_EW'(MAX_ELEMS)) begin
                too_long <= 1'b1;
            end else begin
                idx    <= {idx[IDX_W-2:0], (elem == ELEM_DASH)};
                n_elem <= n_elem + 1'b1;
            end
        end
    end

    // Purpose: arm one space after a character, disarm on a new element or the space.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_pend <= 1'b0;
        end else if (emit_char) begin
            word_pend <= 1'b1;
        end else if (emit_space || (elem != ELEM_NONE)) begin
            word_pend <= 1'b0;
        end
    end

    // Purpose: record a byte lost to a full FIFO until the next reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow <= 1'b0;
        end else if (emit && fifo_full) begin
            overflow <= 1'b1;
        end
    end

    AST_OVF_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && fifo_full) |=> overflow); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R8
    AST_ELEM_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        n_elem <= CNT_EW'(MAX_ELEMS)); // R6
    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |=> !fifo_wr); // R9

endmodule

// File: rtl/morse_decoder.sv
// Top level of the adaptive Morse decoder: edge timer, adaptive
// classifier and tree assembler in a chain.
// Assumes key_in is synchronous and debounced no further than its own edges.
module morse_decoder
    import morse_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int UNIT_INIT = 60,
    parameter int UNIT_MIN  = 8,
    parameter int UNIT_MAX  = 2000,
    parameter int MAX_ELEMS = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_in,
    input  logic       fifo_full,
    output logic       fifo_wr,
    output logic [7:0] fifo_data,
    output logic       overflow
);

    logic             key_lvl, tone_done, char_end, word_end;
    logic [CNT_W-1:0] run_len, tone_len, unit;
    elem_t            elem;

    morse_edge_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_in    (key_in),
        .key_lvl   (key_lvl),
        .run_len   (run_len),
        .tone_done (tone_done),
        .tone_len  (tone_len)
    );

    morse_classifier #(
        .CNT_W     (CNT_W),
        .UNIT_INIT (UNIT_INIT),
        .UNIT_MIN  (UNIT_MIN),
        .UNIT_MAX  (UNIT_MAX)
    ) u_class (
        .clk       (clk),
        .rst_n     (rst_n),
        .tone_done (tone_done),
        .tone_len  (tone_len),
        .key_lvl   (key_lvl),
        .run_len   (run_len),
        .elem      (elem),
        .char_end  (char_end),
        .word_end  (word_end),
        .unit      (unit)
    );

    morse_assembler #(.MAX_ELEMS(MAX_ELEMS)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .elem      (elem),
        .char_end  (char_end),
        .word_end  (word_end),
        .fifo_full (fifo_full),
        .fifo_wr   (fifo_wr),
        .fifo_data (fifo_data),
        .overflow  (overflow)
    );

endmodule

// File: tb/tb_morse_decoder.sv
module tb_morse_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_in = 1'b0;
    logic       fifo_full = 1'b0;
    logic       fifo_wr;
    logic [7:0] fifo_data;
    logic       overflow;

    int n_chk = 0;
    int n_fail = 0;
    int cap_n = 0;
    int rd = 0;
    int dbl = 0;
    logic prev_wr = 1'b0;
    logic [7:0] cap [128];

    always #2 clk = ~clk;

    morse_decoder #(
        .CNT_W(10), .UNIT_INIT(8), .UNIT_MIN(4), .UNIT_MAX(32), .MAX_ELEMS(6)
    ) dut (
        .clk(clk), .rst_n(rst_n), .key_in(key_in), .fifo_full(fifo_full),
        .fifo_wr(fifo_wr), .fifo_data(fifo_data), .overflow(overflow)
    );

    // Capture FIFO writes away from the active edge; count back-to-back strobes.
    always @(negedge clk) begin
        if (rst_n && fifo_wr) begin
            if (cap_n < 128) cap[cap_n] = fifo_data;
            cap_n = cap_n + 1;
            if (prev_wr) dbl = dbl + 1;
        end
        prev_wr = rst_n && fifo_wr;
    end

    // Vector: {unit[7:0], count[2:0], elements[5:0] first at MSB of count, ascii[7:0]}; dot=0 dash=1
    localparam int NV = 17;
    localparam logic [24:0] VEC [NV] = '{
        {8'd8,  3'd1, 6'b000000, 8'h45}, // E
        {8'd8,  3'd1, 6'b000001, 8'h54}, // T
        {8'd8,  3'd2, 6'b000001, 8'h41}, // A
        {8'd8,  3'd2, 6'b000010, 8'h4E}, // N
        {8'd8,  3'd3, 6'b000000, 8'h53}, // S
        {8'd8,  3'd3, 6'b000111, 8'h4F}, // O
        {8'd10, 3'd3, 6'b000101, 8'h4B}, // K
        {8'd10, 3'd5, 6'b011111, 8'h30}, // 0
        {8'd12, 3'd4, 6'b000000, 8'h48}, // H
        {8'd12, 3'd5, 6'b000000, 8'h35}, // 5
        {8'd12, 3'd3, 6'b000010, 8'h52}, // R
        {8'd10, 3'd4, 6'b000011, 8'h3F}, // unlisted ..--
        {8'd10, 3'd6, 6'b010101, 8'h2E}, // .
        {8'd8,  3'd5, 6'b001111, 8'h31}, // 1
        {8'd8,  3'd2, 6'b000000, 8'h49}, // I
        {8'd6,  3'd3, 6'b000000, 8'h53}, // S
        {8'd4,  3'd5, 6'b010000, 8'h36}  // 6
    };

    task automatic tone(input int n);
        key_in = 1'b1;
        repeat (n) @(negedge clk);
        key_in = 1'b0;
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_pat(input int u, input int len, input logic [5:0] bits);
        for (int i = 0; i < len; i++) begin
            tone(bits[len-1-i] ? 3*u : u);
            if (i < len - 1) gap(u);
        end
        gap(3*u);
    endtask

    task automatic check_next(input string req, input logic [7:0] exp);
        #1;
        n_chk++;
        if (rd >= cap_n) begin
            n_fail++;
            $display("FAIL %s: no byte written, expected %h", req, exp);
        end else begin
            if (cap[rd] !== exp) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", req, cap[rd], exp);
            end
            rd++;
        end
    endtask

    task automatic check_none(input string req);
        #1;
        n_chk++;
        if (cap_n != rd) begin
            n_fail++;
            $display("FAIL %s: %0d unexpected bytes, expected 0", req, cap_n - rd);
            rd = cap_n;
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        #1;
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        check_bit("R1 wr in reset", fifo_wr, 1'b0);
        check_bit("R1 overflow in reset", overflow, 1'b0);
        rst_n = 1'b1;
        gap(300);
        check_none("R7 idle line");
        check_bit("R1 overflow after reset", overflow, 1'b0);

        // R4 R7: character then word gap gives the byte then one space
        send_pat(8, 1, 6'b0);
        gap(32);
        check_next("R4 char in gap", 8'h45);
        check_next("R7 word space", 8'h20);
        gap(200);
        check_none("R7 single space");

        // R2: glitch inside a character is ignored
        tone(8); gap(8); tone(2); gap(8); tone(24); gap(24);
        gap(40);
        check_next("R2 glitch ignored", 8'h41);
        check_next("R7 space after A", 8'h20);

        // R2: overlong tone adds nothing
        tone(60); gap(60);
        check_none("R2 overlong tone");
        send_pat(8, 1, 6'b0);
        gap(40);
        check_next("R2 after overlong", 8'h45);
        check_next("R7 space after E", 8'h20);

        // R6: seven dots
        for (int k = 0; k < 7; k++) begin
            tone(8);
            if (k < 6) gap(8);
        end
        gap(64);
        check_next("R6 too many elements", 8'h3F);
        check_next("R7 space after ?", 8'h20);

        // R8: full FIFO drops and flags
        fifo_full = 1'b1;
        send_pat(8, 1, 6'b1);
        gap(40);
        check_none("R8 no write while full");
        check_bit("R8 overflow set", overflow, 1'b1);
        fifo_full = 1'b0;
        send_pat(8, 1, 6'b0);
        gap(40);
        check_next("R8 write after full clears", 8'h45);
        check_next("R8 space after E", 8'h20);
        check_bit("R8 overflow sticky", overflow, 1'b1);

        // R2 R3 R5: vector table across changing send rates
        for (int v = 0; v < NV; v++) begin
            send_pat(int'(VEC[v][24:17]), int'(VEC[v][16:14]), VEC[v][13:8]);
            check_next("R5 table", VEC[v][7:0]);
        end
        gap(40);
        check_next("R7 space after table", 8'h20);

        // R3: estimate is at 4; 2-cycle dots would pull it below, clamp keeps it
        tone(2); gap(2); tone(2); gap(16);
        check_next("R3 short dots", 8'h49);
        tone(7); gap(16);
        check_next("R3 clamp keeps 7 a dot", 8'h45);
        gap(20);
        check_next("R7 space after clamp", 8'h20);

        n_chk++;
        if (dbl != 0) begin
            n_fail++;
            $display("FAIL R9: %0d multi-cycle strobes, expected 0", dbl);
        end

        check_bit("R8 overflow before reset", overflow, 1'b1);
        rst_n = 1'b0;
        gap(3);
        rst_n = 1'b1;
        gap(2);
        check_bit("R1 overflow cleared", overflow, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule